// File: doc/BRIEF.md
# Adaptive Recharge Interval Timer

This block paces the refresh of a reference voltage that is held during sleep. It runs off the slow 32 kHz clock. It emits a one-cycle recharge pulse at the end of each interval. Around that pulse it raises a bias request that keeps the bandgap and regulator alive. The recharge interval is configured as a mantissa and an exponent. The same encoding sets an upper limit for the interval and a separate oscillator calibration interval.

When adaptation is switched on, each recharge that completes without an early-need indication lengthens the next interval. The growth is two right-shifted copies of the current interval added to it, and the result is clamped at the programmed limit. An early-need indication from the comparator drops the next interval back to the base value.

The calibration scheduler counts its own interval. In active mode it fires the calibration trigger as soon as the interval ends. In powerdown mode it only records that a calibration is due. The next recharge then also raises the global bias request and fires the calibration trigger alongside the recharge pulse.

Top module: `rch_timer`

## Requirements
- R1: An interval field pair (mantissa m, exponent e) encodes a length in clocks of ({m, five 1 bits}) << e, which is (32*m+31)*2^e. With adaptation off, recharge pulses come exactly that many clocks apart. The first pulse comes that many clocks after reset is released.
- R2: recharge_pulse is high for exactly one clock per recharge.
- R3: With adapt_en=1 and early_need=0 during a recharge pulse, the following interval is P + (P >> step_a) + (P >> step_b), where P is the interval that just ended.
- R4: An adapted interval never exceeds the limit interval decoded from lim_mant/lim_exp. A growth step that would pass the limit gives the limit exactly.
- R5: With adapt_en=1 and early_need=1 (active high) during a recharge pulse, the following interval is the base interval.
- R6: The calibration interval uses the R1 encoding. With active=1 (1 = active mode, 0 = powerdown), cal_trig pulses for one clock at the end of every calibration interval.
- R7: A calibration interval that ends while active=0 raises no cal_trig at that time. It is held pending, and at the next recharge pulse cal_trig and gbias_req are both high in the same clock as recharge_pulse.
- R8: bias_req goes high in the clock of recharge_pulse and stays high for HOLD clocks (default 8). gbias_req is high only inside such a window, and only when a calibration was served at that recharge.
- R9: While rst_n is low, all four outputs are 0.
- R10: With adapt_en=0, the interval stays at the base value whatever early_need does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz timer clock |
| rst_n | input | 1 | Active-low reset |
| rc_mant | input | MANT_W | Base recharge interval mantissa |
| rc_exp | input | EXP_W | Base recharge interval exponent |
| lim_mant | input | MANT_W | Limit interval mantissa |
| lim_exp | input | EXP_W | Limit interval exponent |
| adapt_en | input | 1 | Enable adaptive interval growth |
| step_a | input | SH_W | First growth shift (1..10) |
| step_b | input | SH_W | Second growth shift (2..10) |
| cal_mant | input | MANT_W | Calibration interval mantissa |
| cal_exp | input | EXP_W | Calibration interval exponent |
| active | input | 1 | 1 = active mode, 0 = powerdown |
| early_need | input | 1 | Comparator says recharge was needed early |
| recharge_pulse | output | 1 | One-clock recharge strobe |
| bias_req | output | 1 | Bandgap/reference bias request window |
| gbias_req | output | 1 | Global bias request for a served calibration |
| cal_trig | output | 1 | One-clock oscillator calibration trigger |

## Verification
The assertions assume the configuration fields are changed only while the block is in reset. They also assume every decoded interval is at least 31 clocks, which is longer than the bias window, so windows never overlap. A further assumption is that the limit is not below the base interval while adaptation runs. The bench keeps to these rules by programming each case before a reset pulse and holding it steady afterwards, and by using shift values within 1..10. It also drives early_need as a level for a whole case, so its value during every recharge pulse is known.

// File: rtl/rch_pkg.sv
package rch_pkg;
  localparam int PW = 32;
  typedef logic [PW-1:0] per_t;

  // Length in clocks of a mantissa/exponent interval: mantissa with five
  // trailing ones, shifted left by the exponent.
  function automatic per_t ivl_len(input per_t mant, input per_t ex);
    return ((mant << 5) | per_t'(31)) << ex;
  endfunction

  // One adaptation step: add two right-shifted copies, clamp at the limit.
  function automatic per_t adapt_next(input per_t p, input per_t sa,
                                      input per_t sb, input per_t lim);
    per_t s;
    s = p + (p >> sa) + (p >> sb);
    return (s > lim) ? lim : s;
  endfunction
endpackage

// File: rtl/rch_cal_sched.sv
module rch_cal_sched
  import rch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  per_t cal_len,
  output logic expire
);
  per_t cnt_q;

  assign expire = (cnt_q >= cal_len - per_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= expire ? '0 : cnt_q + per_t'(1);
  end

  // R6: intervals are at least 31 clocks, so expiry never repeats back to back
  a_r6_expire_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/rch_period_ctrl.sv
module rch_period_ctrl
  import rch_pkg::*;
#(
  parameter int SH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  per_t            base,
  input  per_t            lim,
  input  logic            adapt_en,
  input  logic [SH_W-1:0] step_a,
  input  logic [SH_W-1:0] step_b,
  input  logic            early_need,
  output logic            fire,
  output logic            pulse
);
  per_t cnt_q, per_q, eff;
  logic grown_q;

  assign eff  = (adapt_en && grown_q) ? per_q : base;
  assign fire = (cnt_q >= eff - per_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      grown_q <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse <= fire;
      cnt_q <= fire ? '0 : cnt_q + per_t'(1);
      if (pulse) begin
        if (!adapt_en || early_need) begin
          grown_q <= 1'b0;
        end else begin
          per_q   <= adapt_next(eff, per_t'(step_a), per_t'(step_b), lim);
          grown_q <= 1'b1;
        end
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  a_r4_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    grown_q |-> (per_q <= lim));

  a_r5_early_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && early_need) |=> !grown_q);

  a_r10_no_adapt: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !adapt_en) |=> !grown_q);
endmodule

// File: rtl/rch_bias_window.sv
module rch_bias_window #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic with_gb,
  output logic bias,
  output logic gbias
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      bias   <= 1'b0;
      gbias  <= 1'b0;
    end else if (start) begin
      left_q <= CW'(HOLD - 1);
      bias   <= 1'b1;
      gbias  <= with_gb;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end else begin
      bias  <= 1'b0;
      gbias <= 1'b0;
    end
  end

  a_r8_gbias_inside: assert property (@(posedge clk) disable iff (!rst_n)
    gbias |-> bias);
endmodule

// File: rtl/rch_timer.sv
module rch_timer
  import rch_pkg::*;
#(
  parameter int MANT_W = 6,
  parameter int EXP_W  = 4,
  parameter int SH_W   = 4,
  parameter int HOLD   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] rc_mant,
  input  logic [EXP_W-1:0]  rc_exp,
  input  logic [MANT_W-1:0] lim_mant,
  input  logic [EXP_W-1:0]  lim_exp,
  input  logic              adapt_en,
  input  logic [SH_W-1:0]   step_a,
  input  logic [SH_W-1:0]   step_b,
  input  logic [MANT_W-1:0] cal_mant,
  input  logic [EXP_W-1:0]  cal_exp,
  input  logic              active,
  input  logic              early_need,
  output logic              recharge_pulse,
  output logic              bias_req,
  output logic              gbias_req,
  output logic              cal_trig
);
  localparam int NIVL = 3;

  logic [MANT_W-1:0] mant_v [NIVL];
  logic [EXP_W-1:0]  exp_v  [NIVL];
  per_t              len_v  [NIVL];

  assign mant_v[0] = rc_mant;
  assign exp_v[0]  = rc_exp;
  assign mant_v[1] = lim_mant;
  assign exp_v[1]  = lim_exp;
  assign mant_v[2] = cal_mant;
  assign exp_v[2]  = cal_exp;

  for (genvar g = 0; g < NIVL; g++) begin : g_dec
    assign len_v[g] = ivl_len(per_t'(mant_v[g]), per_t'(exp_v[g]));
  end

  logic fire, cal_fire, serve, pend_q;

  rch_period_ctrl #(.SH_W(SH_W)) u_period (
    .clk(clk), .rst_n(rst_n), .base(len_v[0]), .lim(len_v[1]),
    .adapt_en(adapt_en), .step_a(step_a), .step_b(step_b),
    .early_need(early_need), .fire(fire), .pulse(recharge_pulse));

  rch_cal_sched u_cal (
    .clk(clk), .rst_n(rst_n), .cal_len(len_v[2]), .expire(cal_fire));

  // A calibration is served by this recharge if one is pending or one
  // expires in powerdown in the very same clock.
  assign serve = fire && (pend_q || (cal_fire && !active));

  rch_bias_window #(.HOLD(HOLD)) u_win (
    .clk(clk), .rst_n(rst_n), .start(fire), .with_gb(serve),
    .bias(bias_req), .gbias(gbias_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      cal_trig <= 1'b0;
    end else begin
      cal_trig <= (cal_fire && active) || serve;
      if (serve)         pend_q <= 1'b0;
      else if (cal_fire) pend_q <= !active;
    end
  end

  a_r6_active_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_fire && active) |=> cal_trig);

  a_r7_served_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (recharge_pulse && gbias_req) |-> cal_trig);

  a_r7_pend_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(!active));

  a_r8_pulse_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    recharge_pulse |-> bias_req);
endmodule

// File: tb/rch_timer_bench.sv
`timescale 1ns/1ps
module rch_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] rc_mant = '0, lim_mant = '0, cal_mant = '0;
  logic [3:0] rc_exp = '0, lim_exp = '0, cal_exp = '0;
  logic [3:0] step_a = 4'd1, step_b = 4'd2;
  logic adapt_en = 1'b0, active = 1'b1, early_need = 1'b0;
  logic recharge_pulse, bias_req, gbias_req, cal_trig;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rch_timer u_rch_timer (
    .clk(clk), .rst_n(rst_n), .rc_mant(rc_mant), .rc_exp(rc_exp),
    .lim_mant(lim_mant), .lim_exp(lim_exp), .adapt_en(adapt_en),
    .step_a(step_a), .step_b(step_b), .cal_mant(cal_mant), .cal_exp(cal_exp),
    .active(active), .early_need(early_need), .recharge_pulse(recharge_pulse),
    .bias_req(bias_req), .gbias_req(gbias_req), .cal_trig(cal_trig));

  typedef struct packed {
    logic [5:0] m;  logic [3:0] e;  logic ad;
    logic [3:0] sa; logic [3:0] sb;
    logic [5:0] mm; logic [3:0] me; logic early;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{6'd0, 4'd0, 1'b0, 4'd1, 4'd2, 6'd0,  4'd0, 1'b0},
    '{6'd2, 4'd1, 1'b0, 4'd1, 4'd2, 6'd0,  4'd0, 1'b0},
    '{6'd1, 4'd2, 1'b1, 4'd1, 4'd2, 6'd63, 4'd3, 1'b0},
    '{6'd0, 4'd1, 1'b1, 4'd3, 4'd5, 6'd5,  4'd0, 1'b0},
    '{6'd3, 4'd0, 1'b1, 4'd1, 4'd2, 6'd3,  4'd1, 1'b0},
    '{6'd1, 4'd1, 1'b1, 4'd1, 4'd2, 6'd10, 4'd2, 1'b1},
    '{6'd2, 4'd0, 1'b0, 4'd1, 4'd2, 6'd63, 4'd3, 1'b1},
    '{6'd0, 4'd0, 1'b1, 4'd2, 4'd10, 6'd63, 4'd3, 1'b0}
  };

  function automatic int blen(input int m, input int e);
    return (m * 32 + 31) * (1 << e);
  endfunction

  function automatic int grow(input int p, input int a, input int b, input int lim);
    int s;
    s = p + p / (1 << a) + p / (1 << b);
    return (s > lim) ? lim : s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!recharge_pulse && n < 100000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, w, pw, e1, e2, e3, lim;
    // R9: outputs quiet in reset
    cal_mant = 6'd63; cal_exp = 4'd15;
    repeat (3) @(negedge clk);
    check("R9 reset pulse", recharge_pulse, 0);
    check("R9 reset bias", bias_req, 0);
    check("R9 reset gbias", gbias_req, 0);
    check("R9 reset cal", cal_trig, 0);

    // Vector walk: R1, R3, R4, R5, R10
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rc_mant = VECS[i].m;   rc_exp = VECS[i].e;
      adapt_en = VECS[i].ad; step_a = VECS[i].sa; step_b = VECS[i].sb;
      lim_mant = VECS[i].mm; lim_exp = VECS[i].me;
      early_need = VECS[i].early; active = 1'b1;
      do_reset();
      lim = blen(VECS[i].mm, VECS[i].me);
      e1 = blen(VECS[i].m, VECS[i].e);
      e2 = (VECS[i].ad && !VECS[i].early) ? grow(e1, VECS[i].sa, VECS[i].sb, lim) : e1;
      e3 = (VECS[i].ad && !VECS[i].early) ? grow(e2, VECS[i].sa, VECS[i].sb, lim) : e1;
      wait_pulse(n); check("R1 first interval", n, e1);
      wait_pulse(n); check("R3/R4/R5/R10 second interval", n, e2);
      wait_pulse(n); check("R3/R4/R5/R10 third interval", n, e3);
    end

    // R2 and R8: pulse width and bias window, no calibration pending
    @(negedge clk);
    rc_mant = 6'd0; rc_exp = 4'd0; adapt_en = 1'b0; early_need = 1'b0;
    cal_mant = 6'd63; cal_exp = 4'd15; active = 1'b0;
    do_reset();
    wait_pulse(n);
    check("R8 gbias idle without pending", gbias_req, 0);
    check("R7 no cal without pending", cal_trig, 0);
    w = 0; pw = 1;
    while (bias_req && w < 100) begin
      w++;
      @(negedge clk);
      if (w == 1) pw = recharge_pulse;
    end
    check("R2 pulse one clock", pw, 0);
    check("R8 bias window length", w, 8);

    // R6: active calibration at 62 clocks
    @(negedge clk);
    rc_mant = 6'd3; rc_exp = 4'd2; cal_mant = 6'd0; cal_exp = 4'd1; active = 1'b1;
    do_reset();
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!cal_trig && n < 1000);
      check("R6 active cal interval", n, 62);
      @(negedge clk);
      check("R6 cal one clock", cal_trig, 0);
      n = 1;
      do begin @(negedge clk); n++; end while (!cal_trig && n < 1000);
      check("R6 active cal repeat", n, 62);
      if (k == 0) begin @(negedge clk); end
      break;
    end

    // R7: powerdown expiry deferred to the recharge
    @(negedge clk);
    rc_mant = 6'd2; rc_exp = 4'd1; cal_mant = 6'd0; cal_exp = 4'd1; active = 1'b0;
    do_reset();
    pw = 0; n = 0;
    do begin
      @(negedge clk); n++;
      if (cal_trig && !recharge_pulse) pw++;
    end while (!recharge_pulse && n < 1000);
    check("R7 no early cal in powerdown", pw, 0);
    check("R7 recharge interval", n, 190);
    check("R7 cal with recharge", cal_trig, 1);
    check("R7 gbias with recharge", gbias_req, 1);
    w = 0;
    while (gbias_req && w < 100) begin w++; @(negedge clk); end
    check("R8 gbias window length", w, 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule